// File: doc/BRIEF.md
# UART Register Block

This block is a serial port that a processor drives through eight byte-wide registers. The registers sit on a 32-bit bus, one per 4-byte word. A write to the data word starts a transmit frame. Received frames land in a receive buffer that the processor collects by reading that same word. Status comes back through a line-status register and an interrupt-cause register, and a single level interrupt line tells the processor when a transfer has finished.

Two state machines do the serial work.

The transmitter moves through `TX_IDLE`, `TX_START`, `TX_DATA`, `TX_STOP` and `TX_FINISH`:
- A data write moves it from any state to `TX_START`. If the divisor is zero it goes straight to `TX_FINISH` instead.
- `TX_START` moves to `TX_DATA` after one bit time.
- `TX_DATA` moves to `TX_STOP` after the last data bit.
- `TX_STOP` moves to `TX_FINISH` after one bit time.
- `TX_FINISH` returns to `TX_IDLE` after one clock, and it marks completion in that clock.

The receiver moves through `RX_IDLE`, `RX_START`, `RX_DATA`, `RX_STOP` and `RX_DELIVER`:
- It leaves `RX_IDLE` for `RX_START` when the synchronised line goes low and the divisor is nonzero.
- In `RX_START` it waits half a bit time. It then goes to `RX_DATA` if the line is still low, or back to `RX_IDLE` if it is not.
- `RX_DATA` samples one bit per bit time and moves to `RX_STOP` after the last one.
- `RX_STOP` goes to `RX_DELIVER` on a high stop bit and to `RX_IDLE` on a low one.
- `RX_DELIVER` hands the byte over and returns to `RX_IDLE`.

Top module: `uart_regblk`

## Requirements
- R1: After reset the line-status word (offset 0x14) reads 0x20 and every other register reads 0. The interrupt is low and the serial output is high.
- R2: The registers are word aligned on a 4-byte stride, and each register keeps only the low byte of a write:
  - 0x00 is the data word: receive buffer on read, transmit data on write.
  - 0x04 is the interrupt enable.
  - 0x08 is the interrupt cause.
  - 0x0C is the line control.
  - 0x10 and 0x18 are plain storage.
  - 0x14 is the line status.
  - 0x1C is the divisor.
  - Bits 31:8 of every read are 0.
- R3: Any other offset (0x20 and up, or low address bits not 00) reads as 0, and a write to it changes no register.
- R4: A write to the data word clears line-status bit 5 and interrupt-cause bit 1. When the frame completes, line-status bit 5 is set and the interrupt cause becomes 0x02. With a divisor of 0, completion is visible on the clock after the write.
- R5: Transmit completion drives the interrupt high when interrupt-enable bit 1 is set, and leaves it alone otherwise.
- R6: Interrupt-enable writes behave as follows:
  - Bit 1 set while line-status bit 5 is set: interrupt-cause bit 1 is set and the interrupt goes high.
  - Bit 1 set while a frame is in flight: the interrupt is unchanged.
  - Bit 1 clear: the interrupt goes low.
- R7: With a nonzero divisor D, the serial output is high when idle and each frame is sent LSB first. The frame is a low start bit, the data bits, then a high stop bit, each lasting D clocks.
- R8: Line-control bits [1:0] set the word length, on both the transmit and receive paths:
  - 00 gives 5 bits.
  - 01 gives 6 bits.
  - 10 gives 7 bits.
  - 11 gives 8 bits.
  The transmitted character is masked to that length.
- R9: A received frame with a high stop bit loads the receive buffer, sets line-status bit 0 and sets the interrupt cause to 0x04. It drives the interrupt high when interrupt-enable bit 0 is set.
- R10: A read of the data word clears line-status bit 0.
- R11: A received frame with a low stop bit is dropped, leaving the buffer and line-status bit 0 unchanged. Reception is disabled while the divisor is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 6 | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one clock per access |
| bus_rd | input | 1 | Read strobe; marks the read for side effects |
| bus_wdata | input | 32 | Write data, low byte used |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt |
| ser_txd | output | 1 | Serial transmit line |
| ser_rxd | input | 1 | Serial receive line, asynchronous |

## Verification
Most wrong internal states show up on a status read in the next clock. A transmitter stuck in one state never sets line-status bit 5, so polling for it times out. A wrong bit counter or word-length decode changes the frame on `ser_txd` within a few bit times, and the serial monitor compares each frame against the queued character. A receiver state error either drops a good frame or accepts a bad one. Both are seen through line-status bit 0 and the buffer contents about one bit time after the stop bit.

// File: rtl/uart_pkg.sv
package uart_pkg;

    localparam int REG_W = 8;

    localparam int LSR_RX_BIT = 0;
    localparam int LSR_TX_BIT = 5;
    localparam int IER_RX_BIT = 0;
    localparam int IER_TX_BIT = 1;

    localparam logic [REG_W-1:0] LSR_RESET   = 8'h20;
    localparam logic [REG_W-1:0] IIR_TX_CODE = 8'h02;
    localparam logic [REG_W-1:0] IIR_RX_CODE = 8'h04;

    typedef enum logic [2:0] {
        IDX_DATA = 3'd0,
        IDX_IER  = 3'd1,
        IDX_IIR  = 3'd2,
        IDX_LCR  = 3'd3,
        IDX_MCR  = 3'd4,
        IDX_LSR  = 3'd5,
        IDX_MSR  = 3'd6,
        IDX_DIV  = 3'd7
    } reg_idx_e;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_STOP,
        TX_FINISH
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_DELIVER
    } rx_state_e;

    // Mask that keeps 5..8 low bits, selected by a 2-bit word-length code.
    function automatic logic [REG_W-1:0] wl_mask(input logic [1:0] wl);
        return 8'hFF >> (2'd3 - wl);
    endfunction

    // Index of the last data bit (4..7) for a word-length code.
    function automatic logic [2:0] wl_last(input logic [1:0] wl);
        return 3'd4 + {1'b0, wl};
    endfunction

endpackage

// File: rtl/uart_tx.sv
module uart_tx
    import uart_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [REG_W-1:0] char_in,
    input  logic [1:0]       wl,
    input  logic [REG_W-1:0] divisor,
    output logic             txd,
    output logic             done
);

    tx_state_e        state_q, state_d;
    logic [REG_W-1:0] cnt_q, cnt_d;
    logic [REG_W-1:0] sh_q, sh_d;
    logic [2:0]       idx_q, idx_d;
    logic [2:0]       last_q, last_d;
    logic [REG_W-1:0] reload;

    assign reload = divisor - 1'b1;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        sh_d    = sh_q;
        idx_d   = idx_q;
        last_d  = last_q;
        unique case (state_q)
            TX_IDLE: begin
            end
            TX_START: begin
                if (cnt_q == '0) begin
                    state_d = TX_DATA;
                    cnt_d   = reload;
                    idx_d   = '0;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            TX_DATA: begin
                if (cnt_q == '0) begin
                    cnt_d = reload;
                    sh_d  = sh_q >> 1;
                    if (idx_q == last_q) begin
                        state_d = TX_STOP;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            TX_STOP: begin
                if (cnt_q == '0) begin
                    state_d = TX_FINISH;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            TX_FINISH: begin
                state_d = TX_IDLE;
            end
            default: begin
                state_d = TX_IDLE;
            end
        endcase
        // A new character restarts the shifter from any state.
        if (start) begin
            sh_d    = char_in & wl_mask(wl);
            last_d  = wl_last(wl);
            cnt_d   = reload;
            state_d = (divisor == '0) ? TX_FINISH : TX_START;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            cnt_q   <= '0;
            sh_q    <= '0;
            idx_q   <= '0;
            last_q  <= 3'd7;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            sh_q    <= sh_d;
            idx_q   <= idx_d;
            last_q  <= last_d;
        end
    end

    always_comb begin
        unique case (state_q)
            TX_START: txd = 1'b0;
            TX_DATA:  txd = sh_q[0];
            default:  txd = 1'b1;
        endcase
        done = (state_q == TX_FINISH);
    end

endmodule

// File: rtl/uart_rx.sv
module uart_rx
    import uart_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rxd_raw,
    input  logic [1:0]       wl,
    input  logic [REG_W-1:0] divisor,
    output logic             done,
    output logic [REG_W-1:0] data
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   rxs;

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q[0] <= 1'b1;
                else        sync_q[0] <= rxd_raw;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q[g] <= 1'b1;
                else        sync_q[g] <= sync_q[g-1];
            end
        end
    end

    assign rxs = sync_q[SYNC_STAGES-1];

    rx_state_e        state_q, state_d;
    logic [REG_W-1:0] cnt_q, cnt_d;
    logic [REG_W-1:0] buf_q, buf_d;
    logic [2:0]       idx_q, idx_d;
    logic [2:0]       last_q, last_d;
    logic [REG_W-1:0] reload;

    assign reload = divisor - 1'b1;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        buf_d   = buf_q;
        idx_d   = idx_q;
        last_d  = last_q;
        unique case (state_q)
            RX_IDLE: begin
                if (divisor != '0 && !rxs) begin
                    state_d = RX_START;
                    cnt_d   = divisor >> 1;
                    last_d  = wl_last(wl);
                end
            end
            RX_START: begin
                if (cnt_q == '0) begin
                    if (!rxs) begin
                        state_d = RX_DATA;
                        cnt_d   = reload;
                        idx_d   = '0;
                        buf_d   = '0;
                    end else begin
                        state_d = RX_IDLE;
                    end
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            RX_DATA: begin
                if (cnt_q == '0) begin
                    buf_d[idx_q] = rxs;
                    cnt_d        = reload;
                    if (idx_q == last_q) begin
                        state_d = RX_STOP;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            RX_STOP: begin
                if (cnt_q == '0) begin
                    state_d = rxs ? RX_DELIVER : RX_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            RX_DELIVER: begin
                state_d = RX_IDLE;
            end
            default: begin
                state_d = RX_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
            buf_q   <= '0;
            idx_q   <= '0;
            last_q  <= 3'd7;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            buf_q   <= buf_d;
            idx_q   <= idx_d;
            last_q  <= last_d;
        end
    end

    always_comb begin
        done = (state_q == RX_DELIVER);
        data = buf_q;
    end

endmodule

// File: rtl/uart_regblk.sv
module uart_regblk
    import uart_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              ser_txd,
    input  logic              ser_rxd
);

    localparam int SEL_W    = ADDR_W - 2;
    localparam int NUM_REGS = 8;

    logic [SEL_W-1:0] sel;
    logic             mapped;
    reg_idx_e         idx;
    logic [REG_W-1:0] wbyte;
    logic             thr_wr, ier_wr, rbr_rd;

    logic [REG_W-1:0] ier_q, iir_q, lcr_q, mcr_q, lsr_q, msr_q, div_q, rbr_q;
    logic             irq_q;

    logic             tx_done, rx_done;
    logic [REG_W-1:0] rx_data;

    wire unused_wdata = ^bus_wdata[DATA_W-1:REG_W];

    assign sel    = bus_addr[ADDR_W-1:2];
    assign mapped = (bus_addr[1:0] == 2'b00) && (sel < SEL_W'(NUM_REGS));
    assign idx    = reg_idx_e'(sel[2:0]);
    assign wbyte  = bus_wdata[REG_W-1:0];
    assign thr_wr = bus_wr && mapped && idx == IDX_DATA;
    assign ier_wr = bus_wr && mapped && idx == IDX_IER;
    assign rbr_rd = bus_rd && mapped && idx == IDX_DATA;

    uart_tx u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (thr_wr),
        .char_in (wbyte),
        .wl      (lcr_q[1:0]),
        .divisor (div_q),
        .txd     (ser_txd),
        .done    (tx_done)
    );

    uart_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .rxd_raw (ser_rxd),
        .wl      (lcr_q[1:0]),
        .divisor (div_q),
        .done    (rx_done),
        .data    (rx_data)
    );

    // Later statements take priority: bus storage, read clear, line events,
    // transmit-data write, then enable write.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ier_q <= '0;
            iir_q <= '0;
            lcr_q <= '0;
            mcr_q <= '0;
            lsr_q <= LSR_RESET;
            msr_q <= '0;
            div_q <= '0;
            rbr_q <= '0;
            irq_q <= 1'b0;
        end else begin
            if (bus_wr && mapped) begin
                case (idx)
                    IDX_IIR: iir_q <= wbyte;
                    IDX_LCR: lcr_q <= wbyte;
                    IDX_MCR: mcr_q <= wbyte;
                    IDX_LSR: lsr_q <= wbyte;
                    IDX_MSR: msr_q <= wbyte;
                    IDX_DIV: div_q <= wbyte;
                    default: ;
                endcase
            end
            if (rbr_rd) begin
                lsr_q[LSR_RX_BIT] <= 1'b0;
            end
            if (tx_done) begin
                lsr_q[LSR_TX_BIT] <= 1'b1;
                iir_q             <= IIR_TX_CODE;
                if (ier_q[IER_TX_BIT]) irq_q <= 1'b1;
            end
            if (rx_done) begin
                rbr_q             <= rx_data;
                lsr_q[LSR_RX_BIT] <= 1'b1;
                iir_q             <= IIR_RX_CODE;
                if (ier_q[IER_RX_BIT]) irq_q <= 1'b1;
            end
            if (thr_wr) begin
                lsr_q[LSR_TX_BIT] <= 1'b0;
                iir_q[1]          <= 1'b0;
            end
            if (ier_wr) begin
                ier_q <= wbyte;
                if (wbyte[IER_TX_BIT] && lsr_q[LSR_TX_BIT]) begin
                    iir_q[1] <= 1'b1;
                    irq_q    <= 1'b1;
                end else if (!wbyte[IER_TX_BIT]) begin
                    irq_q <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (mapped) begin
            unique case (idx)
                IDX_DATA: bus_rdata[REG_W-1:0] = rbr_q;
                IDX_IER:  bus_rdata[REG_W-1:0] = ier_q;
                IDX_IIR:  bus_rdata[REG_W-1:0] = iir_q;
                IDX_LCR:  bus_rdata[REG_W-1:0] = lcr_q;
                IDX_MCR:  bus_rdata[REG_W-1:0] = mcr_q;
                IDX_LSR:  bus_rdata[REG_W-1:0] = lsr_q;
                IDX_MSR:  bus_rdata[REG_W-1:0] = msr_q;
                IDX_DIV:  bus_rdata[REG_W-1:0] = div_q;
                default:  bus_rdata = '0;
            endcase
        end
        irq = irq_q;
    end

endmodule

// File: rtl/uart_regblk_chk.sv
module uart_regblk_chk #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq,
    input logic [7:0]        lsr_q,
    input logic [7:0]        iir_q,
    input logic [7:0]        ier_q,
    input logic              tx_done,
    input logic              rx_done
);

    logic at_data, at_ier;
    assign at_data = (bus_addr == ADDR_W'(8'h00));
    assign at_ier  = (bus_addr == ADDR_W'(8'h04));

    // R2: upper read bits are always zero
    a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:8] == '0);

    // R4: a transmit-data write empties the holding status
    a_r4_thr_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && at_data) |=> !lsr_q[5]);

    // R4: completion sets ready and the transmit cause code
    a_r4_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && !bus_wr && !rx_done) |=> (lsr_q[5] && iir_q == 8'h02));

    // R5: completion with the transmit enable raises the interrupt
    a_r5_tx_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && ier_q[1] && !bus_wr) |=> irq);

    // R6: enabling while empty raises the interrupt
    a_r6_ier_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && at_ier && bus_wdata[1] && lsr_q[5]) |=> (irq && iir_q[1]));

    // R6: clearing the transmit enable drops the interrupt
    a_r6_ier_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && at_ier && !bus_wdata[1]) |=> !irq);

    // R9: a delivered frame flags receive-ready
    a_r9_rx_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !bus_wr) |=> (lsr_q[0] && iir_q == 8'h04));

    // R10: reading the buffer clears receive-ready
    a_r10_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && at_data && !rx_done && !bus_wr) |=> !lsr_q[0]);

endmodule

bind uart_regblk uart_regblk_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .lsr_q     (lsr_q),
    .iir_q     (iir_q),
    .ier_q     (ier_q),
    .tx_done   (tx_done),
    .rx_done   (rx_done)
);

// File: tb/sim_uart_regblk.sv
module sim_uart_regblk;

    localparam int CLK_PERIOD = 10;
    localparam int BT         = 4;

    localparam logic [5:0] A_DATA = 6'h00;
    localparam logic [5:0] A_IER  = 6'h04;
    localparam logic [5:0] A_IIR  = 6'h08;
    localparam logic [5:0] A_LCR  = 6'h0C;
    localparam logic [5:0] A_MCR  = 6'h10;
    localparam logic [5:0] A_LSR  = 6'h14;
    localparam logic [5:0] A_MSR  = 6'h18;
    localparam logic [5:0] A_DIV  = 6'h1C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        ser_txd;
    logic        ser_rxd = 1'b1;

    int checks = 0;
    int errors = 0;
    int mon_bits = 8;
    int mon_div  = BT;
    logic [7:0] tx_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_regblk u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq),
        .ser_txd   (ser_txd),
        .ser_rxd   (ser_rxd)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic bwrite(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic bread(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk);
        #1 bus_rd = 1'b0;
    endtask

    task automatic rcheck(input string tag, input logic [5:0] a, input logic [31:0] exp);
        logic [31:0] v;
        bread(a, v);
        chk(tag, v, exp);
    endtask

    // Driver: queue the expected line character, then write it.
    task automatic send_tx(input logic [7:0] ch, input logic [7:0] exp, input int bits);
        mon_bits = bits;
        tx_q.push_back(exp);
        bwrite(A_DATA, {24'hABCDEF, ch});
    endtask

    task automatic wait_tx_ready();
        logic [31:0] v;
        for (int i = 0; i < 400; i++) begin
            bread(A_LSR, v);
            if (v[5]) break;
        end
    endtask

    task automatic send_rx(input logic [7:0] ch, input int bits, input logic stop_bit);
        @(negedge clk);
        ser_rxd = 1'b0;
        repeat (BT) @(negedge clk);
        for (int i = 0; i < bits; i++) begin
            ser_rxd = ch[i];
            repeat (BT) @(negedge clk);
        end
        ser_rxd = stop_bit;
        repeat (BT) @(negedge clk);
        ser_rxd = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    // Monitor: decode each frame on the line and compare with the queue (R7, R8).
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && ser_txd === 1'b0) begin
                logic [7:0] got;
                logic       start_ok, stop_v;
                got = '0;
                repeat (mon_div/2) @(negedge clk);
                start_ok = (ser_txd === 1'b0);
                for (int i = 0; i < mon_bits; i++) begin
                    repeat (mon_div) @(negedge clk);
                    got[i] = ser_txd;
                end
                repeat (mon_div) @(negedge clk);
                stop_v = ser_txd;
                chk("R7 start bit low", {31'b0, start_ok}, 32'd1);
                chk("R7 stop bit high", {31'b0, stop_v}, 32'd1);
                if (tx_q.size() == 0) begin
                    chk("R7 unexpected frame", {24'b0, got}, 32'hFFFF_FFFF);
                end else begin
                    chk("R8 frame data", {24'b0, got}, {24'b0, tx_q.pop_front()});
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rcheck("R1 lsr", A_LSR, 32'h20);
        rcheck("R1 ier", A_IER, 32'h0);
        rcheck("R1 iir", A_IIR, 32'h0);
        rcheck("R1 lcr", A_LCR, 32'h0);
        rcheck("R1 mcr", A_MCR, 32'h0);
        rcheck("R1 msr", A_MSR, 32'h0);
        rcheck("R1 div", A_DIV, 32'h0);
        rcheck("R1 rbr", A_DATA, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'd0);
        chk("R1 txd", {31'b0, ser_txd}, 32'd1);

        // R2 low byte storage on the stride
        bwrite(A_MCR, 32'h1234_5678);
        rcheck("R2 mcr", A_MCR, 32'h78);
        bwrite(A_MSR, 32'hA5A5_A5C3);
        rcheck("R2 msr", A_MSR, 32'hC3);
        bwrite(A_LCR, 32'hFFFF_FF03);
        rcheck("R2 lcr", A_LCR, 32'h03);

        // R3 unmapped offsets
        bwrite(6'h20, 32'hFF);
        rcheck("R3 read 0x20", 6'h20, 32'h0);
        rcheck("R3 misaligned read", 6'h0D, 32'h0);
        bwrite(6'h11, 32'h55);
        rcheck("R3 misaligned write ignored", A_MCR, 32'h78);

        // R4 zero divisor: done on the following clock
        bwrite(A_DATA, 32'h41);
        rcheck("R4 lsr right after write", A_LSR, 32'h00);
        rcheck("R4 lsr one clock later", A_LSR, 32'h20);
        rcheck("R4 iir tx code", A_IIR, 32'h02);
        chk("R5 no irq when disabled", {31'b0, irq}, 32'd0);

        // R6 enable while empty raises, clear drops
        bwrite(A_IIR, 32'h0);
        bwrite(A_IER, 32'h02);
        chk("R6 irq raised", {31'b0, irq}, 32'd1);
        rcheck("R6 iir bit set", A_IIR, 32'h02);
        bwrite(A_IER, 32'h00);
        chk("R6 irq dropped", {31'b0, irq}, 32'd0);

        // R5/R7 serial frame with divisor 4, 8 bits
        bwrite(A_DIV, BT);
        send_tx(8'hA5, 8'hA5, 8);
        rcheck("R4 iir cleared by write", A_IIR, 32'h00);
        bwrite(A_IER, 32'h02);
        chk("R6 no irq while busy", {31'b0, irq}, 32'd0);
        wait_tx_ready();
        chk("R5 irq on completion", {31'b0, irq}, 32'd1);
        rcheck("R4 iir after frame", A_IIR, 32'h02);
        bwrite(A_IER, 32'h00);

        // R8 word-length masking
        bwrite(A_LCR, 32'h0);
        send_tx(8'hFF, 8'h1F, 5);
        wait_tx_ready();
        bwrite(A_LCR, 32'h1);
        send_tx(8'hC6, 8'h06, 6);
        wait_tx_ready();
        bwrite(A_LCR, 32'h2);
        send_tx(8'hD5, 8'h55, 7);
        wait_tx_ready();
        repeat (2 * BT) @(negedge clk);
        chk("R5 irq stays low when disabled", {31'b0, irq}, 32'd0);

        // R9/R10 reception
        bwrite(A_LCR, 32'h3);
        bwrite(A_IER, 32'h01);
        send_rx(8'h3C, 8, 1'b1);
        rcheck("R9 lsr rx ready", A_LSR, 32'h21);
        rcheck("R9 iir rx code", A_IIR, 32'h04);
        chk("R9 irq", {31'b0, irq}, 32'd1);
        rcheck("R9 rbr data", A_DATA, 32'h3C);
        rcheck("R10 lsr cleared by read", A_LSR, 32'h20);
        bwrite(A_IER, 32'h00);

        // R8 five-bit reception
        bwrite(A_LCR, 32'h0);
        send_rx(8'h15, 5, 1'b1);
        rcheck("R8 rx 5-bit lsr", A_LSR, 32'h21);
        rcheck("R8 rx 5-bit data", A_DATA, 32'h15);

        // R11 bad stop bit and zero divisor
        bwrite(A_LCR, 32'h3);
        send_rx(8'h77, 8, 1'b0);
        rcheck("R11 bad stop lsr", A_LSR, 32'h20);
        rcheck("R11 bad stop rbr kept", A_DATA, 32'h15);
        bwrite(A_DIV, 32'h0);
        send_rx(8'h99, 8, 1'b1);
        rcheck("R11 div0 lsr", A_LSR, 32'h20);
        rcheck("R11 div0 rbr kept", A_DATA, 32'h15);

        chk("R7 all frames seen", tx_q.size(), 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule